// File: doc/BRIEF.md
# Fine-Grain Least-Recently-Used Thread Selector

This block is the thread-pick stage of a four-thread scalar pipeline. Every thread has its own program counter, registers and buffers, so moving from one thread to another costs nothing. In each clock cycle the selector looks at all threads. It picks the ready thread that has gone longest without issuing and reports that thread's index together with an issue-valid flag. One instruction of that thread then enters the pipeline.

A thread is held back for several reasons. It may have no instruction. A level stall from a cache miss, a trap or a resource conflict may be active. Its last issued instruction may still be in flight: a branch, a multiply/divide, or a load inside its hit-latency shadow. It may also be waiting on a refill after a load miss. Load data comes back in the third cycle after issue. A thread that issued a load therefore sits out two cycles and may then issue again on the guess that the load hit. If the miss strobe arrives one cycle later, the selector cancels that speculative instruction. The thread then stays parked until a refill strobe arrives.

Top module: `fg_thread_select`

## Requirements
- R1: `issue_valid_o` is high only when at least one thread is ready in that cycle. When it is high, `issue_tid_o` names a thread whose `inst_valid_i` bit is set. When no thread is ready, `issue_valid_o` is low.
- R2: Among the ready threads, the one whose last issue is oldest wins. Right after reset the age order, from oldest to newest, is thread 0, 1, 2, 3.
- R3: The age order changes only in a cycle with an issue, and then the issued thread becomes the newest. A cycle without an issue leaves the order unchanged.
- R4: A thread whose `stall_i` bit is high is not selected in that same cycle.
- R5: A thread that issues a load (kind code 2'b01) is not selected in the next two cycles. It may be selected again in the third cycle, which is a speculative issue.
- R6: A thread that issues a branch (kind code 2'b10) is not selected in the next cycle only.
- R7: A thread that issues a multiply/divide (kind code 2'b11) is not selected from the next cycle until the cycle after its `muldiv_done_i` strobe. A strobe in the issue cycle itself is ignored.
- R8: A `load_miss_i` strobe arrives in the fourth cycle after the load issued. It blocks that thread in the same cycle and in every cycle up to and including the cycle of its `fill_i` strobe. The thread is eligible again in the cycle after the fill.
- R9: In the miss cycle, `cancel_o` for that thread is high exactly when the thread issued a speculative instruction in the cycle before. Otherwise it is low.
- R10: Reset clears every thread's blocking state and restores the age order given in R2.
- Kind code 2'b00 is a plain ALU instruction, which blocks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_valid_i | input | NT | Thread has a next instruction |
| inst_kind_i | input | NT x 2 | Decoded kind of each thread's next instruction |
| stall_i | input | NT | Level stall (cache miss, trap, resource conflict) |
| load_miss_i | input | NT | Load miss strobe, one cycle after the speculative slot |
| fill_i | input | NT | Miss refill strobe |
| muldiv_done_i | input | NT | Multiply/divide completion strobe |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_tid_o | output | log2(NT) | Index of the issuing thread |
| cancel_o | output | NT | Cancel the speculative instruction of a thread |

## Verification
The assertions take certain things for granted about the inputs. A thread gets `load_miss_i` only in the single cycle that falls four cycles after it issued a load. It gets `fill_i` only while it is waiting on a miss, and `muldiv_done_i` only while a multiply/divide is outstanding. The stimulus follows these rules because it tracks each thread's state from the requirements alone. It raises a miss, a refill or a completion only when the tracked state permits one, and it draws each of them with a random chance. Everything else is drawn freely: the instruction-valid bits, the instruction kinds and the stalls.

// File: rtl/fgts_pkg.sv
package fgts_pkg;
  typedef enum logic [1:0] {
    KIND_ALU    = 2'b00,
    KIND_LOAD   = 2'b01,
    KIND_BRANCH = 2'b10,
    KIND_MULDIV = 2'b11
  } inst_kind_e;
endpackage

// File: rtl/fgts_thread_state.sv
module fgts_thread_state
  import fgts_pkg::*;
#(
  parameter int LD_SHADOW = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inst_valid_i,
  input  logic [1:0] inst_kind_i,
  input  logic       stall_i,
  input  logic       load_miss_i,
  input  logic       fill_i,
  input  logic       muldiv_done_i,
  input  logic       issued_i,
  output logic       ready_o,
  output logic       cancel_o
);
  // pipe bit i set = load issued i+1 cycles ago
  localparam int PW       = LD_SHADOW + 2;
  localparam int SPEC_BIT = LD_SHADOW;
  localparam int MISS_BIT = LD_SHADOW + 1;

  inst_kind_e kind;
  logic [PW-1:0] ld_pipe_q;
  logic spec_q, br_q, md_q, miss_q;
  logic shadow, miss_ev;

  assign kind    = inst_kind_e'(inst_kind_i);
  assign shadow  = |ld_pipe_q[LD_SHADOW-1:0];
  assign miss_ev = load_miss_i & ld_pipe_q[MISS_BIT];

  assign ready_o  = inst_valid_i & ~stall_i & ~shadow & ~br_q & ~md_q
                  & ~miss_q & ~load_miss_i;
  assign cancel_o = miss_ev & spec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pipe_q <= '0;
      spec_q    <= 1'b0;
      br_q      <= 1'b0;
      md_q      <= 1'b0;
      miss_q    <= 1'b0;
    end else if (miss_ev) begin
      // drop everything issued under the failed hit guess
      ld_pipe_q <= '0;
      spec_q    <= 1'b0;
      br_q      <= 1'b0;
      md_q      <= 1'b0;
      miss_q    <= 1'b1;
    end else begin
      ld_pipe_q <= {ld_pipe_q[PW-2:0], issued_i && (kind == KIND_LOAD)};
      spec_q    <= ld_pipe_q[SPEC_BIT] & issued_i;
      br_q      <= issued_i && (kind == KIND_BRANCH);
      if (issued_i && (kind == KIND_MULDIV)) md_q <= 1'b1;
      else if (muldiv_done_i)                md_q <= 1'b0;
      if (fill_i) miss_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fgts_lru_pick.sv
module fgts_lru_pick #(
  parameter int NT = 4,
  parameter int TW = $clog2(NT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NT-1:0]          ready_i,
  output logic                   pick_valid_o,
  output logic [TW-1:0]          pick_tid_o,
  output logic [NT-1:0][TW-1:0]  ord_o
);
  // ord_q[0] = least recently issued
  logic [NT-1:0][TW-1:0] ord_q, ord_n;
  logic [TW-1:0] pos_sel;
  logic          found;

  always_comb begin
    found   = 1'b0;
    pos_sel = '0;
    for (int i = 0; i < NT; i++) begin
      if (!found && ready_i[ord_q[i]]) begin
        found   = 1'b1;
        pos_sel = TW'(i);
      end
    end
  end

  assign pick_valid_o = found;
  assign pick_tid_o   = ord_q[pos_sel];
  assign ord_o        = ord_q;

  always_comb begin
    ord_n = ord_q;
    for (int i = 0; i < NT - 1; i++) begin
      if (i >= int'(pos_sel)) ord_n[i] = ord_q[i+1];
    end
    ord_n[NT-1] = ord_q[pos_sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NT; i++) ord_q[i] <= TW'(i);
    end else if (found) begin
      ord_q <= ord_n;
    end
  end
endmodule

// File: rtl/fg_thread_select.sv
module fg_thread_select #(
  parameter int NT        = 4,
  parameter int LD_SHADOW = 2,
  localparam int TW       = $clog2(NT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NT-1:0]        inst_valid_i,
  input  logic [NT-1:0][1:0]   inst_kind_i,
  input  logic [NT-1:0]        stall_i,
  input  logic [NT-1:0]        load_miss_i,
  input  logic [NT-1:0]        fill_i,
  input  logic [NT-1:0]        muldiv_done_i,
  output logic                 issue_valid_o,
  output logic [TW-1:0]        issue_tid_o,
  output logic [NT-1:0]        cancel_o
);
  logic [NT-1:0]         thr_ready;
  logic [NT-1:0]         thr_issued;
  logic [NT-1:0][TW-1:0] lru_ord;

  for (genvar k = 0; k < NT; k++) begin : g_thr
    assign thr_issued[k] = issue_valid_o && (issue_tid_o == TW'(k));

    fgts_thread_state #(.LD_SHADOW(LD_SHADOW)) u_state (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .inst_valid_i  (inst_valid_i[k]),
      .inst_kind_i   (inst_kind_i[k]),
      .stall_i       (stall_i[k]),
      .load_miss_i   (load_miss_i[k]),
      .fill_i        (fill_i[k]),
      .muldiv_done_i (muldiv_done_i[k]),
      .issued_i      (thr_issued[k]),
      .ready_o       (thr_ready[k]),
      .cancel_o      (cancel_o[k])
    );
  end

  fgts_lru_pick #(.NT(NT), .TW(TW)) u_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ready_i      (thr_ready),
    .pick_valid_o (issue_valid_o),
    .pick_tid_o   (issue_tid_o),
    .ord_o        (lru_ord)
  );
endmodule

// File: rtl/fg_thread_select_chk.sv
module fg_thread_select_chk
  import fgts_pkg::*;
#(
  parameter int NT        = 4,
  parameter int TW        = 2,
  parameter int LD_SHADOW = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NT-1:0]        inst_valid_i,
  input logic [NT-1:0][1:0]   inst_kind_i,
  input logic [NT-1:0]        stall_i,
  input logic [NT-1:0]        load_miss_i,
  input logic                 issue_valid_o,
  input logic [TW-1:0]        issue_tid_o,
  input logic [NT-1:0]        cancel_o,
  input logic [NT-1:0][TW-1:0] ord_i
);
  logic [NT-1:0] iss;
  always_comb begin
    iss = '0;
    if (issue_valid_o) iss[issue_tid_o] = 1'b1;
  end

  assert_valid_thr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> inst_valid_i[issue_tid_o]);
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_valid_i == '0) |-> !issue_valid_o);
  assert_newest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |=> ord_i[NT-1] == $past(issue_tid_o));
  assert_order_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |=> $stable(ord_i));
  assert_no_stalled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> !stall_i[issue_tid_o]);

  for (genvar k = 0; k < NT; k++) begin : g_k
    assert_ld_shadow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss[k] && inst_kind_i[k] == KIND_LOAD) |=> !iss[k]);
    if (LD_SHADOW >= 2) begin : g_two
      assert_ld_shadow2_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss[k] && inst_kind_i[k] == KIND_LOAD) |-> ##2 !iss[k]);
    end
    assert_branch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss[k] && inst_kind_i[k] == KIND_BRANCH) |=> !iss[k]);
    assert_muldiv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss[k] && inst_kind_i[k] == KIND_MULDIV) |=> !iss[k]);
    assert_miss_now_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_miss_i[k] |-> !iss[k]);
    assert_miss_next_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_miss_i[k] |=> !iss[k]);
    assert_cancel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cancel_o[k] |-> load_miss_i[k]);
  end
endmodule

bind fg_thread_select fg_thread_select_chk #(.NT(NT), .TW(TW), .LD_SHADOW(LD_SHADOW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .inst_valid_i  (inst_valid_i),
  .inst_kind_i   (inst_kind_i),
  .stall_i       (stall_i),
  .load_miss_i   (load_miss_i),
  .issue_valid_o (issue_valid_o),
  .issue_tid_o   (issue_tid_o),
  .cancel_o      (cancel_o),
  .ord_i         (lru_ord)
);

// File: tb/fg_thread_select_tb.sv
module fg_thread_select_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NT-1:0]      inst_valid = '0;
  logic [NT-1:0][1:0] inst_kind  = '0;
  logic [NT-1:0]      stall = '0, load_miss = '0, fill = '0, md_done = '0;
  logic               issue_valid_o;
  logic [1:0]         issue_tid_o;
  logic [NT-1:0]      cancel_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // reference state built from the requirements
  int       m_ord [NT];
  bit [3:0] m_pipe[NT];
  bit       m_spec[NT], m_br[NT], m_md[NT], m_miss[NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  fg_thread_select #(.NT(NT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .inst_valid_i(inst_valid), .inst_kind_i(inst_kind),
    .stall_i(stall), .load_miss_i(load_miss), .fill_i(fill), .muldiv_done_i(md_done),
    .issue_valid_o(issue_valid_o), .issue_tid_o(issue_tid_o), .cancel_o(cancel_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NT; k++) begin
      m_ord[k] = k; m_pipe[k] = '0; m_spec[k] = 0; m_br[k] = 0; m_md[k] = 0; m_miss[k] = 0;
    end
  endtask

  function automatic bit m_ready(int k);
    return inst_valid[k] && !stall[k] && m_pipe[k][1:0] == 2'b00 && !m_br[k]
        && !m_md[k] && !m_miss[k] && !load_miss[k];
  endfunction

  task automatic drive(input logic [3:0] v, input logic [7:0] kd, input logic [3:0] st,
                       input logic [3:0] lm, input logic [3:0] fl, input logic [3:0] dn);
    int pos;
    int et;
    bit ev;
    @(negedge clk);
    inst_valid = v; inst_kind = kd; stall = st; load_miss = lm; fill = fl; md_done = dn;
    #1;
    ev = 0; pos = 0; et = 0;
    for (int i = 0; i < NT; i++)
      if (!ev && m_ready(m_ord[i])) begin ev = 1; pos = i; et = m_ord[i]; end
    chk("R1 issue_valid", issue_valid_o, ev);
    if (ev) chk("R2 issue_tid", issue_tid_o, et);
    for (int k = 0; k < NT; k++)
      chk("R9 cancel", cancel_o[k], load_miss[k] && m_pipe[k][3] && m_spec[k]);
    for (int k = 0; k < NT; k++) begin
      bit isk;
      isk = ev && et == k;
      if (load_miss[k] && m_pipe[k][3]) begin
        m_miss[k] = 1; m_pipe[k] = '0; m_spec[k] = 0; m_md[k] = 0; m_br[k] = 0;
      end else begin
        m_spec[k] = m_pipe[k][2] && isk;
        m_pipe[k] = {m_pipe[k][2:0], isk && inst_kind[k] == 2'b01};
        m_br[k]   = isk && inst_kind[k] == 2'b10;
        if (isk && inst_kind[k] == 2'b11) m_md[k] = 1;
        else if (md_done[k]) m_md[k] = 0;
        if (fill[k]) m_miss[k] = 0;
      end
    end
    if (ev) begin
      for (int i = pos; i < NT - 1; i++) m_ord[i] = m_ord[i+1];
      m_ord[NT-1] = et;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    inst_valid = '0; load_miss = '0; fill = '0; md_done = '0; stall = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog R1 actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    int s;
    s = $urandom(32'h5eed);
    model_reset();
    repeat (3) @(negedge clk);
    chk("R10 reset idle", issue_valid_o, 0);
    rst_ni = 1'b1;

    // R2/R3: all ready ALU -> oldest-first rotation from reset order
    for (int c = 0; c < 5; c++) begin
      drive(4'hF, 8'h00, 0, 0, 0, 0);
      chk("R2 rotation", issue_tid_o, c % 4);
    end
    // R3: idle cycles leave order untouched
    drive(4'h0, 8'h00, 0, 0, 0, 0);
    chk("R1 none ready", issue_valid_o, 0);
    drive(4'h0, 8'h00, 0, 0, 0, 0);
    drive(4'hF, 8'h00, 0, 0, 0, 0);
    chk("R3 order held", issue_tid_o, 1);
    // R2 subset {0,3}; order 2,3,0,1
    drive(4'b1001, 8'h00, 0, 0, 0, 0);
    chk("R2 subset", issue_tid_o, 3);
    drive(4'b1001, 8'h00, 0, 0, 0, 0);
    chk("R2 subset", issue_tid_o, 0);
    // R4: order 2,1,3,0 ; stall 2
    drive(4'hF, 8'h00, 4'b0100, 0, 0, 0);
    chk("R4 stall skip", issue_tid_o, 1);
    // R6 branch on thread 2
    drive(4'b0100, 8'b0010_0000, 0, 0, 0, 0);
    chk("R6 branch issue", issue_tid_o, 2);
    drive(4'b0100, 8'h00, 0, 0, 0, 0);
    chk("R6 blocked", issue_valid_o, 0);
    drive(4'b0100, 8'h00, 0, 0, 0, 0);
    chk("R6 released", issue_valid_o, 1);
    // R5/R8/R9: load on thread 3, speculative issue, miss, fill
    drive(4'b1000, 8'b0100_0000, 0, 0, 0, 0);
    chk("R5 load issue", issue_tid_o, 3);
    drive(4'b1000, 8'h00, 0, 0, 0, 0);
    chk("R5 shadow 1", issue_valid_o, 0);
    drive(4'b1000, 8'h00, 0, 0, 0, 0);
    chk("R5 shadow 2", issue_valid_o, 0);
    drive(4'b1000, 8'h00, 0, 0, 0, 0);
    chk("R5 speculative", issue_valid_o, 1);
    drive(4'b1000, 8'h00, 0, 4'b1000, 0, 0);
    chk("R8 miss blocks", issue_valid_o, 0);
    chk("R9 cancel set", cancel_o[3], 1);
    drive(4'b1000, 8'h00, 0, 0, 0, 0);
    chk("R8 waiting", issue_valid_o, 0);
    drive(4'b1000, 8'h00, 0, 0, 4'b1000, 0);
    chk("R8 fill cycle", issue_valid_o, 0);
    drive(4'b1000, 8'h00, 0, 0, 0, 0);
    chk("R8 after fill", issue_valid_o, 1);
    // R9 negative: no speculative issue before miss
    drive(4'b1000, 8'b0100_0000, 0, 0, 0, 0);
    drive(4'b0000, 8'h00, 0, 0, 0, 0);
    drive(4'b0000, 8'h00, 0, 0, 0, 0);
    drive(4'b0000, 8'h00, 0, 0, 0, 0);
    drive(4'b1000, 8'h00, 0, 4'b1000, 0, 0);
    chk("R9 no cancel", cancel_o[3], 0);
    drive(4'b0000, 8'h00, 0, 0, 4'b1000, 0);
    // R7: multiply/divide on thread 1, done in issue cycle ignored
    drive(4'b0010, 8'b0000_1100, 0, 0, 0, 4'b0010);
    chk("R7 md issue", issue_tid_o, 1);
    drive(4'b0010, 8'h00, 0, 0, 0, 0);
    chk("R7 busy", issue_valid_o, 0);
    drive(4'b0010, 8'h00, 0, 0, 0, 4'b0010);
    chk("R7 done cycle", issue_valid_o, 0);
    drive(4'b0010, 8'h00, 0, 0, 0, 0);
    chk("R7 released", issue_valid_o, 1);

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      logic [3:0] v, st, lm, fl, dn;
      logic [7:0] kd;
      kd = 8'($urandom);
      for (int k = 0; k < NT; k++) begin
        v[k]  = ($urandom % 10) < 8;
        st[k] = ($urandom % 10) == 0;
        lm[k] = m_pipe[k][3] && ($urandom % 10) < 4;
        fl[k] = m_miss[k] && ($urandom % 10) < 3;
        dn[k] = m_md[k] && ($urandom % 10) < 3;
      end
      drive(v, kd, st, lm, fl, dn);
    end

    // R10: reset mid-flight with thread 0 parked on a miss
    drive(4'b0001, 8'b0000_0001, 0, 0, 0, 0);
    while (!m_pipe[0][3]) drive(4'b0000, 8'h00, 0, 0, 0, 0);
    drive(4'b0000, 8'h00, 0, 4'b0001, 0, 0);
    do_reset();
    drive(4'hF, 8'h00, 0, 0, 0, 0);
    chk("R10 order and state cleared", issue_tid_o, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule